// File: doc/BRIEF.md
# Receive Frame Store Controller

This block sits behind a serial deframer and stores the bytes of each received frame into a shared byte-wide buffer memory. It writes through a single request/acknowledge port. When a frame is complete, it posts two status bytes into fixed locations of that memory and raises a one-cycle interrupt. A frame is complete only when a start marker is followed by a stop marker. The status bytes are a checksum verdict and a payload length.

The deframer gives a start strobe, a stop strobe and a byte strobe with its data. An external CRC16 engine is cleared by the same start strobe and is fed every frame byte. One cycle after each byte, it returns its running value with a valid strobe. The final two bytes of a frame are the transmitted CRC, high byte first. The block compares them with the CRC value it recorded before those two bytes arrived. A frame is dropped without status if the bit clock disappears while it is being received, if a second start marker arrives before the stop, or if it is too short. A frame that overruns the buffer is reported with a dedicated length code.

Top module: `rx_frame_store`

## Requirements
- R1: After reset, `mem_req` and `irq` are low, and no memory write occurs until a start strobe is followed by a byte strobe.
- R2: The n-th byte of a frame (n from 0) is written to address 0x100+n. `mem_req`, `mem_addr` and `mem_wdata` are held steady from the request until the cycle `mem_ack` is seen high.
- R3: A stop strobe that does not follow a start strobe causes no memory write and no interrupt.
- R4: On a complete frame, address 0x1FE is written with 0xFF when the last two bytes, read as {high, low}, equal the CRC value that was reported before those two bytes. Otherwise it is written with 0x00.
- R5: After the write to 0x1FE is acknowledged, address 0x1FF is written with the number of bytes received minus two. The two CRC bytes are therefore not counted.
- R6: Bytes that arrive after 254 bytes have been stored are not written. For such a frame, address 0x1FF is written with 0xFE. A frame of exactly 254 bytes is stored in full and reports 252.
- R7: `irq` is high for exactly one cycle, after the write to 0x1FF has been acknowledged. It pulses once for each frame that posts status.
- R8: A start strobe that arrives during a frame discards that frame without status. Buffering then restarts at address 0x100.
- R9: If `bclk_ok` is low while a frame is being received, the frame is dropped. No status is written, even when a stop strobe follows.
- R10: A frame of fewer than two bytes that ends with a stop strobe posts no status and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_ok | input | 1 | Bit clock present |
| frm_start | input | 1 | Frame start marker strobe |
| frm_stop | input | 1 | Frame stop marker strobe |
| frm_valid | input | 1 | Frame byte strobe |
| frm_data | input | 8 | Frame byte |
| crc_valid | input | 1 | CRC engine result strobe |
| crc_value | input | 16 | Running CRC16 value |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 9 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory write accepted |
| irq | output | 1 | Status posted pulse |

## Verification
The checker assumes three things about the inputs. Frame bytes never arrive while a write is still waiting for its acknowledge. The CRC strobe for a byte lands before the next byte or the stop strobe. The arbiter acknowledges a request only while it is raised. The stimulus keeps to these by spacing bytes five cycles apart. In that test, the modelled arbiter acknowledges on the first cycle a request is visible. The modelled CRC engine answers one cycle after each byte.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_CRC,
    ST_LEN,
    ST_FIN
  } rxfs_state_t;

  typedef struct packed {
    logic [8:0] addr;
    logic [7:0] data;
  } rxfs_wr_t;

endpackage

// File: rtl/rxfs_crc_track.sv
module rxfs_crc_track #(
  parameter int CRC_W = 16,
  parameter logic [15:0] CRC_INIT = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic             crc_vld,
  input  logic [CRC_W-1:0] crc_in,
  output logic             match
);
  localparam int HIST = 3;

  logic [CRC_W-1:0] hist [HIST];
  logic [7:0]       tail_hi, tail_lo;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < HIST; i++) hist[i] <= CRC_INIT;
      tail_hi <= '0;
      tail_lo <= '0;
    end else begin
      if (crc_vld) begin
        hist[0] <= crc_in;
        for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
      end
      if (byte_vld) begin
        tail_hi <= tail_lo;
        tail_lo <= byte_in;
      end
    end
  end

  assign match = (hist[HIST-1] == {tail_hi, tail_lo});

endmodule

// File: rtl/rxfs_wr_port.sv
module rxfs_wr_port
  import rxfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  rxfs_wr_t   cmd,
  input  logic       ack,
  output logic       req,
  output logic [8:0] addr,
  output logic [7:0] wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else if (issue) begin
      req   <= 1'b1;
      addr  <= cmd.addr;
      wdata <= cmd.data;
    end else if (ack) begin
      req   <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_frame_store.sv
module rx_frame_store
  import rxfs_pkg::*;
#(
  parameter logic [8:0]  BUF_BASE = 9'h100,
  parameter logic [8:0]  BUF_LAST = 9'h1FD,
  parameter logic [8:0]  CRC_ADDR = 9'h1FE,
  parameter logic [8:0]  LEN_ADDR = 9'h1FF,
  parameter logic [7:0]  ERR_LEN  = 8'hFE,
  parameter logic [15:0] CRC_INIT = 16'h0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bclk_ok,
  input  logic        frm_start,
  input  logic        frm_stop,
  input  logic        frm_valid,
  input  logic [7:0]  frm_data,
  input  logic        crc_valid,
  input  logic [15:0] crc_value,
  output logic        mem_req,
  output logic [8:0]  mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  output logic        irq
);
  localparam int CAP   = int'(BUF_LAST) - int'(BUF_BASE) + 1;
  localparam int CNT_W = $clog2(CAP + 1);
  localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAP);
  localparam logic [CNT_W-1:0] TWO_C = CNT_W'(2);

  rxfs_state_t      state;
  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             verdict;
  logic             crc_pass;
  logic             issue;
  rxfs_wr_t         cmd;
  logic             take_byte;

  rxfs_crc_track #(.CRC_W(16), .CRC_INIT(CRC_INIT)) u_track (
    .clk      (clk),
    .rst      (rst),
    .clear    (frm_start),
    .byte_vld (frm_valid),
    .byte_in  (frm_data),
    .crc_vld  (crc_valid),
    .crc_in   (crc_value),
    .match    (crc_pass)
  );

  rxfs_wr_port u_port (
    .clk   (clk),
    .rst   (rst),
    .issue (issue),
    .cmd   (cmd),
    .ack   (mem_ack),
    .req   (mem_req),
    .addr  (mem_addr),
    .wdata (mem_wdata)
  );

  assign take_byte = (state == ST_RECV) && bclk_ok && !frm_start &&
                     !frm_stop && frm_valid;

  always_comb begin
    issue    = 1'b0;
    cmd.addr = '0;
    cmd.data = '0;
    unique case (state)
      ST_RECV: begin
        if (take_byte && (cnt < CAP_C)) begin
          issue    = 1'b1;
          cmd.addr = BUF_BASE + 9'(cnt);
          cmd.data = frm_data;
        end
      end
      ST_CRC: begin
        if (!mem_req) begin
          issue    = 1'b1;
          cmd.addr = CRC_ADDR;
          cmd.data = verdict ? 8'hFF : 8'h00;
        end
      end
      ST_LEN: begin
        if (!mem_req) begin
          issue    = 1'b1;
          cmd.addr = LEN_ADDR;
          cmd.data = ovf ? ERR_LEN : 8'(cnt - TWO_C);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      ovf     <= 1'b0;
      verdict <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (frm_start && bclk_ok) begin
            state <= ST_RECV;
            cnt   <= '0;
            ovf   <= 1'b0;
          end
        end
        ST_RECV: begin
          if (!bclk_ok) begin
            state <= ST_IDLE;
          end else if (frm_start) begin
            cnt <= '0;
            ovf <= 1'b0;
          end else if (frm_stop) begin
            if (ovf || (cnt >= TWO_C)) begin
              state   <= ST_CRC;
              verdict <= crc_pass;
            end else begin
              state <= ST_IDLE;
            end
          end else if (frm_valid) begin
            if (cnt < CAP_C) cnt <= cnt + 1'b1;
            else             ovf <= 1'b1;
          end
        end
        ST_CRC: if (!mem_req) state <= ST_LEN;
        ST_LEN: if (!mem_req) state <= ST_FIN;
        ST_FIN: begin
          if (!mem_req) begin
            state <= ST_IDLE;
            irq   <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxfs_checker.sv
module rxfs_checker (
  input logic       clk,
  input logic       rst,
  input logic       frm_valid,
  input logic       mem_req,
  input logic [8:0] mem_addr,
  input logic [7:0] mem_wdata,
  input logic       mem_ack,
  input logic       irq
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)); // R2
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    mem_ack |=> !mem_req); // R2
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[8]); // R2
  AST_ERRLEN_ONLY_LEN: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_addr == 9'h1FF && mem_wdata > 8'hFE |-> 1'b0); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    irq |-> !mem_req); // R7
  AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(!mem_req)); // R7
  AST_SPACED_BYTES: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !frm_valid); // R2
endmodule

bind rx_frame_store rxfs_checker u_rxfs_checker (
  .clk       (clk),
  .rst       (rst),
  .frm_valid (frm_valid),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .irq       (irq)
);

// File: tb/rx_frame_store_test.sv
module rx_frame_store_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_ok = 1'b1;
  logic        frm_start = 1'b0, frm_stop = 1'b0, frm_valid = 1'b0;
  logic [7:0]  frm_data = '0;
  logic        crc_valid = 1'b0;
  logic [15:0] crc_value = '0;
  logic        mem_req, mem_ack = 1'b0, irq;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0, errors = 0;
  int irq_seen = 0, irq_exp = 0;
  bit len_acked = 0;
  logic [15:0] crc_run;
  logic [16:0] exp_q [$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_store uut (
    .clk(clk), .rst(rst), .bclk_ok(bclk_ok),
    .frm_start(frm_start), .frm_stop(frm_stop), .frm_valid(frm_valid),
    .frm_data(frm_data), .crc_valid(crc_valid), .crc_value(crc_value),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .irq(irq)
  );

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [8:0] a, logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  // monitor: arbiter model plus scoreboard compare
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && !rst) begin
        mem_ack = 1'b1;
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected write", {mem_addr, mem_wdata}, 0);
        end else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          check({mem_addr, mem_wdata} == e, "R2/R4/R5/R6/R8 write",
                {mem_addr, mem_wdata}, e);
        end
        if (mem_addr == 9'h1FF) len_acked = 1;
      end
    end
  end

  // monitor: interrupt
  initial begin
    bit prev;
    prev = 0;
    forever begin
      @(negedge clk);
      if (irq && !rst) begin
        irq_seen++;
        check(!prev, "R7 irq width", 2, 1);
        check(len_acked, "R7 irq before length ack", 0, 1);
        len_acked = 0;
      end
      prev = irq;
    end
  end

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    frm_valid = 1'b1; frm_data = b;
    crc_run = crc_step(crc_run, b);
    @(negedge clk);
    frm_valid = 1'b0; crc_valid = 1'b1; crc_value = crc_run;
    @(negedge clk);
    crc_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_start;
    @(negedge clk); frm_start = 1'b1; crc_run = 16'h0000;
    @(negedge clk); frm_start = 1'b0;
  endtask

  task automatic pulse_stop;
    @(negedge clk); frm_stop = 1'b1;
    @(negedge clk); frm_stop = 1'b0;
  endtask

  // full frame: n payload bytes plus 2 CRC bytes
  task automatic frame(int n, bit bad, int seed);
    int total;
    logic [15:0] c;
    logic [7:0] lo;
    total = n + 2;
    pulse_start();
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'(i * 7 + seed);
      if (i < 254) push(9'h100 + 9'(i), b);
      send_byte(b);
    end
    c = crc_run;
    lo = bad ? (c[7:0] ^ 8'h01) : c[7:0];
    if (n < 254)     push(9'h100 + 9'(n), c[15:8]);
    if (n + 1 < 254) push(9'h100 + 9'(n + 1), lo);
    send_byte(c[15:8]);
    send_byte(lo);
    push(9'h1FE, bad ? 8'h00 : 8'hFF);
    push(9'h1FF, (total > 254) ? 8'hFE : 8'(n));
    irq_exp++;
    pulse_stop();
    repeat (12) @(negedge clk);
  endtask

  task automatic settle(string req);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(irq_seen == irq_exp, req, irq_seen, irq_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    crc_run = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mem_req == 1'b0, "R1 reset req", mem_req, 0);
    check(irq == 1'b0, "R1 reset irq", irq, 0);
    send_byte(8'h55);                   // R1 byte without start
    settle("R1 no write before start");

    pulse_stop();                       // R3 stop without start
    settle("R3 lone stop");

    frame(5, 0, 3);                     // R2 R4 R5 good frame
    settle("R4 R5 good frame");
    frame(3, 1, 9);                     // R4 bad CRC
    settle("R4 bad crc");
    frame(0, 0, 1);                     // R5 CRC-only frame, length 0
    settle("R5 empty payload");

    frame(252, 0, 2);                   // R6 exactly full buffer
    settle("R6 full buffer");
    frame(258, 0, 4);                   // R6 overflow
    settle("R6 overflow");

    pulse_start();                      // R8 restart
    for (int i = 0; i < 3; i++) begin
      push(9'h100 + 9'(i), 8'hA0 + 8'(i));
      send_byte(8'hA0 + 8'(i));
    end
    frame(4, 0, 6);
    settle("R8 restart");

    pulse_start();                      // R9 bit clock loss
    for (int i = 0; i < 3; i++) begin
      push(9'h100 + 9'(i), 8'hC0 + 8'(i));
      send_byte(8'hC0 + 8'(i));
    end
    @(negedge clk); bclk_ok = 1'b0;
    @(negedge clk); bclk_ok = 1'b1;
    send_byte(8'h11);
    pulse_stop();
    settle("R9 clock loss");

    pulse_start();                      // R10 one-byte frame
    push(9'h100, 8'h3C);
    send_byte(8'h3C);
    pulse_stop();
    settle("R10 short frame");

    frame(2, 0, 8);                     // recovery after drops
    settle("R2 recovery");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule